// File: doc/BRIEF.md
# Segmented LRU Victim Selector

This block holds the replacement state of a single 16-way cache set and names the way to evict whenever the cache allocates a new line. Each way carries a 4-bit recency rank and a reference bit. Together the reference bits split the set into two parts. Ways whose bit is clear form the unprotected part, and the victim is taken from there first. Ways whose bit is set are protected and are only evicted once every way in the set is protected.

Each cycle the surrounding cache reports a hit together with its way number, or requests an allocation, or does neither. The victim output is combinational on the current state, so it is valid in the same cycle as the allocation request that consumes it. A new line is not always inserted unprotected. A 16-bit LFSR together with a mask input decides, with a tunable probability, whether the new line starts protected. An optional aging step removes protection from the least recent line on every allocation. The block also exports the full rank and reference state.

Top module: `slruVictimSel`

## Requirements
- R1: While reset is low and on release, way i holds rank i and every reference bit is clear, so the victim is way 0.
- R2: The sixteen ranks always form a permutation of 0 to 15.
- R3: A hit without an allocation in the same cycle moves the hit way to rank 15 and sets its reference bit. Every way whose rank was above the old rank of the hit way drops by one. No other way changes.
- R4: If at least one reference bit is clear, the victim is the unreferenced way with the lowest rank.
- R5: If all reference bits are set, the victim is the way at rank 0.
- R6: An allocation moves the presented victim way to rank 15. Every way whose rank was above it drops by one.
- R7: The LFSR resets to 16'hACE1 and shifts once per clock: next = {q[14:0], q[15]^q[13]^q[12]^q[10]}. On an allocation, the reference bit of the allocated way becomes 1 exactly when (q & promoMask) == 0, where q is the LFSR value in that cycle.
- R8: With agingEn high, an allocation also clears the reference bit of the way that was at rank 0 before the update. The allocated way itself follows R7.
- R9: With agingEn low, an allocation changes no reference bit other than that of the allocated way.
- R10: When hitValid and allocReq are both high, only the allocation takes effect and the hit is ignored.
- R11: In a cycle with neither a hit nor an allocation, ranks and reference bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| hitValid | input | 1 | A lookup hit this set in this cycle |
| hitWay | input | 4 | Way that hit |
| allocReq | input | 1 | Allocate into the way shown on victimWay |
| promoMask | input | 16 | LFSR bits that must be zero to promote a new line |
| agingEn | input | 1 | Enables clearing of the LRU line's reference bit on allocation |
| victimWay | output | 4 | Way to be replaced on the next allocation |
| rankVec | output | 64 | Rank of way i at bits 4i+3:4i (15 = most recent) |
| refVec | output | 16 | Reference bit of way i at bit i |

## Verification
A wrong rank or reference bit is not always visible on victimWay at once. It can stay hidden behind a protected way until the unprotected part of the set empties. For that reason the full state on rankVec and refVec is compared against a behavioural model after every edge, so any corruption shows up within one clock. A mistimed LFSR step or an off-by-one mask test shows up as a wrong reference bit on the first allocation whose promotion outcome differs.

// File: rtl/slruPkg.sv
package slruPkg;
  localparam int WAYS      = 16;
  localparam int RANK_W    = $clog2(WAYS);
  localparam int LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef struct packed {
    logic              touchEn;
    logic [RANK_W-1:0] touchWay;
    logic              touchRef;
    logic              ageEn;
    logic [RANK_W-1:0] ageWay;
  } ctrlStrobes_t;
endpackage

// File: rtl/slruCtrl.sv
module slruCtrl
  import slruPkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           hitValid,
  input  logic [RANK_W-1:0]              hitWay,
  input  logic                           allocReq,
  input  logic [LFSR_W-1:0]              promoMask,
  input  logic                           agingEn,
  input  logic [WAYS-1:0][RANK_W-1:0]    rankArr,
  input  logic [WAYS-1:0]                refArr,
  output logic [RANK_W-1:0]              victimWay,
  output ctrlStrobes_t                   strb
);
  localparam logic [WAYS-1:0] ALL_REF = '1;

  logic [LFSR_W-1:0] lfsrQ;
  logic              promote;
  logic [WAYS-1:0]   candMask;
  logic [RANK_W-1:0] bestRank;
  logic              found;
  logic [RANK_W-1:0] lruWay;

  always_ff @(posedge clk) begin
    if (!rstN) lfsrQ <= LFSR_SEED;
    else       lfsrQ <= {lfsrQ[LFSR_W-2:0], lfsrQ[15] ^ lfsrQ[13] ^ lfsrQ[12] ^ lfsrQ[10]};
  end

  assign promote = ((lfsrQ & promoMask) == '0);

  // Unreferenced segment first; whole set when it is empty.
  assign candMask = (refArr == ALL_REF) ? ALL_REF : ~refArr;

  always_comb begin
    found     = 1'b0;
    bestRank  = '1;
    victimWay = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (candMask[i] && (!found || rankArr[i] < bestRank)) begin
        found     = 1'b1;
        bestRank  = rankArr[i];
        victimWay = RANK_W'(i);
      end
    end
  end

  always_comb begin
    lruWay = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (rankArr[i] == '0) lruWay = RANK_W'(i);
    end
  end

  always_comb begin
    strb.touchEn  = allocReq | hitValid;
    strb.touchWay = allocReq ? victimWay : hitWay;
    strb.touchRef = allocReq ? promote : 1'b1;
    strb.ageEn    = allocReq & agingEn;
    strb.ageWay   = lruWay;
  end
endmodule

// File: rtl/slruDatapath.sv
module slruDatapath
  import slruPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strb,
  output logic [WAYS-1:0][RANK_W-1:0] rankArr,
  output logic [WAYS-1:0]             refArr
);
  localparam logic [RANK_W-1:0] MRU_RANK = RANK_W'(WAYS - 1);

  logic [RANK_W-1:0] touchRank;
  assign touchRank = rankArr[strb.touchWay];

  for (genvar i = 0; i < WAYS; i++) begin : g_way
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rankArr[i] <= RANK_W'(i);
        refArr[i]  <= 1'b0;
      end else begin
        if (strb.touchEn) begin
          if (strb.touchWay == RANK_W'(i))  rankArr[i] <= MRU_RANK;
          else if (rankArr[i] > touchRank)  rankArr[i] <= rankArr[i] - 1'b1;
        end
        if (strb.touchEn && strb.touchWay == RANK_W'(i)) refArr[i] <= strb.touchRef;
        else if (strb.ageEn && strb.ageWay == RANK_W'(i)) refArr[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slruVictimSel.sv
module slruVictimSel
  import slruPkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hitValid,
  input  logic [RANK_W-1:0]        hitWay,
  input  logic                     allocReq,
  input  logic [LFSR_W-1:0]        promoMask,
  input  logic                     agingEn,
  output logic [RANK_W-1:0]        victimWay,
  output logic [WAYS*RANK_W-1:0]   rankVec,
  output logic [WAYS-1:0]          refVec
);
  ctrlStrobes_t                strb;
  logic [WAYS-1:0][RANK_W-1:0] rankArr;
  logic [WAYS-1:0]             refArr;

  slruCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitWay(hitWay),
    .allocReq(allocReq), .promoMask(promoMask), .agingEn(agingEn),
    .rankArr(rankArr), .refArr(refArr), .victimWay(victimWay), .strb(strb)
  );

  slruDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rankArr(rankArr), .refArr(refArr)
  );

  assign rankVec = rankArr;
  assign refVec  = refArr;
endmodule

// File: rtl/slruChecker.sv
module slruChecker (
  input logic        clk,
  input logic        rstN,
  input logic        hitValid,
  input logic [3:0]  hitWay,
  input logic        allocReq,
  input logic [3:0]  victimWay,
  input logic [63:0] rankVec,
  input logic [15:0] refVec
);
  function automatic logic [3:0] rankOf(input logic [63:0] v, input logic [3:0] w);
    return v[w*4 +: 4];
  endfunction

  function automatic logic [15:0] rankCover(input logic [63:0] v);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < 16; i++) m[v[i*4 +: 4]] = 1'b1;
    return m;
  endfunction

  a_r2_permutation: assert property (@(posedge clk) disable iff (!rstN)
    rankCover(rankVec) == 16'hFFFF);

  a_r3_hit_to_mru: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && !allocReq) |=> (rankOf(rankVec, $past(hitWay)) == 4'd15) && refVec[$past(hitWay)]);

  a_r4_unref_victim: assert property (@(posedge clk) disable iff (!rstN)
    (refVec != 16'hFFFF) |-> !refVec[victimWay]);

  a_r5_all_ref_lru: assert property (@(posedge clk) disable iff (!rstN)
    (refVec == 16'hFFFF) |-> (rankOf(rankVec, victimWay) == 4'd0));

  a_r6_alloc_to_mru: assert property (@(posedge clk) disable iff (!rstN)
    allocReq |=> rankOf(rankVec, $past(victimWay)) == 4'd15);

  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!hitValid && !allocReq) |=> ($stable(rankVec) && $stable(refVec)));
endmodule

bind slruVictimSel slruChecker u_chk (
  .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitWay(hitWay),
  .allocReq(allocReq), .victimWay(victimWay), .rankVec(rankVec), .refVec(refVec)
);

// File: tb/slruVictimSel_test.sv
module slruVictimSel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hitValid = 1'b0;
  logic [3:0]  hitWay = '0;
  logic        allocReq = 1'b0;
  logic [15:0] promoMask = 16'hFFFF;
  logic        agingEn = 1'b1;
  logic [3:0]  victimWay;
  logic [63:0] rankVec;
  logic [15:0] refVec;

  int checks = 0;
  int errors = 0;

  int mRank[16];
  int mRef[16];
  logic [15:0] mLfsr;
  string lastTag = "R1";
  logic lastAlloc = 1'b0;
  int lastVictim = 0;
  int lastPromote = 0;

  always #2 clk = ~clk;

  slruVictimSel uut (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitWay(hitWay),
    .allocReq(allocReq), .promoMask(promoMask), .agingEn(agingEn),
    .victimWay(victimWay), .rankVec(rankVec), .refVec(refVec)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int modelVictim();
    int best = -1;
    bit anyClear = 0;
    for (int i = 0; i < 16; i++) if (mRef[i] == 0) anyClear = 1;
    for (int i = 0; i < 16; i++)
      if ((!anyClear || mRef[i] == 0) && (best < 0 || mRank[i] < mRank[best])) best = i;
    return best;
  endfunction

  function automatic int allRef();
    for (int i = 0; i < 16; i++) if (mRef[i] == 0) return 0;
    return 1;
  endfunction

  task automatic touch(input int w);
    int old = mRank[w];
    for (int i = 0; i < 16; i++) if (mRank[i] > old) mRank[i]--;
    mRank[w] = 15;
  endtask

  task automatic compareAll();
    check(allRef() ? "R5" : "R4", int'(victimWay), modelVictim(), "victim");
    for (int i = 0; i < 16; i++) begin
      check(lastTag, int'(rankVec[i*4 +: 4]), mRank[i], $sformatf("rank of way %0d", i));
      check(lastTag, int'(refVec[i]), mRef[i], $sformatf("ref of way %0d", i));
    end
    if (lastAlloc) begin
      check("R6", int'(rankVec[lastVictim*4 +: 4]), 15, "allocated way rank");
      check("R7", int'(refVec[lastVictim]), lastPromote, "allocated way promotion");
    end
  endtask

  // One cycle: compare at negedge, drive, update model for the coming posedge.
  task automatic step(input bit h, input int hw, input bit a, input logic [15:0] mask, input bit age);
    int v;
    int lru;
    compareAll();
    hitValid = h; hitWay = 4'(hw); allocReq = a; promoMask = mask; agingEn = age;
    lastAlloc = a;
    if (a) begin
      v = modelVictim();
      lru = 0;
      for (int i = 0; i < 16; i++) if (mRank[i] == 0) lru = i;
      if (age) mRef[lru] = 0;
      lastPromote = ((mLfsr & mask) == 16'h0) ? 1 : 0;
      touch(v);
      mRef[v] = lastPromote;
      lastVictim = v;
      lastTag = h ? "R10" : (age ? "R8" : "R9");
    end else if (h) begin
      touch(hw);
      mRef[hw] = 1;
      lastTag = "R3";
    end else begin
      lastTag = "R11";
    end
    mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] masks[3];
    masks[0] = 16'h0000; masks[1] = 16'h001F; masks[2] = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin mRank[i] = i; mRef[i] = 0; end
    mLfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    check("R1", int'(victimWay), 0, "victim in reset");
    check("R1", int'(refVec), 0, "refs in reset");
    check("R1", int'(rankVec[15*4 +: 4]), 15, "rank of way 15 in reset");
    rstN = 1'b1;
    lastTag = "R1";
    // R3: hit every way, reverse order, then some repeats
    for (int w = 15; w >= 0; w--) step(1, w, 0, 16'hFFFF, 1);
    step(1, 7, 0, 16'hFFFF, 1);
    step(0, 0, 0, 16'hFFFF, 1);
    // R5 / R9: all referenced, allocate without aging
    for (int k = 0; k < 4; k++) step(0, 0, 1, 16'hFFFF, 0);
    // R8: aging with forced promotion then no promotion
    for (int k = 0; k < 6; k++) step(0, 0, 1, 16'h0000, 1);
    for (int k = 0; k < 20; k++) step(0, 0, 1, 16'hFFFF, 1);
    // R10: simultaneous hit and allocate
    for (int k = 0; k < 8; k++) step(1, k, 1, 16'h001F, 1);
    // R11: idle run
    for (int k = 0; k < 5; k++) step(0, 0, 0, 16'h0000, 1);
    // R2/R4/R7 mixed traffic
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 9);
      step(r < 5, $urandom_range(0, 15), r >= 4 && r < 8,
           masks[$urandom_range(0, 2)], $urandom_range(0, 1) == 1);
    end
    compareAll();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule